// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Accumulator CPU

This block turns an addressing-mode code and the operand bytes of an instruction into the 16-bit effective address of its operand. Some modes need no memory access: zero page, zero page indexed, absolute, absolute indexed, relative branch target and immediate. These resolve in a single cycle. The three pointer modes fetch a two-byte little-endian pointer through a byte-wide read port that uses a request/acknowledge handshake. When the read has its low byte at offset 0xFF of a page, it takes the high byte from offset 0x00 of the same page, which matches the historic carry flaw of the processor. With the address, the block reports how many extra cycles the mode costs.

A sequencer pulses `start` with the mode, the operands, X, Y, the address of the next instruction and the read-modify-write/store flag. It then waits for the one-cycle `done` pulse and samples `ea` and `extra_cyc` in that cycle. Both outputs hold their values until the next operation finishes.

Mode codes on `mode`: 0 zero page, 1 zero page + X, 2 zero page + Y, 3 absolute, 4 absolute + X, 5 absolute + Y, 6 pointer, 7 pre-indexed pointer, 8 post-indexed pointer, 9 relative branch, 10 immediate. Codes 11 to 15 behave as immediate.

The state machine has four states:
- `ST_IDLE`: waits for `start`. For a direct mode, `start` leads to `ST_DONE`. For a pointer mode, it leads to `ST_LO`.
- `ST_LO`: requests the pointer low byte. `rd_ack` leads to `ST_HI`.
- `ST_HI`: requests the pointer high byte. `rd_ack` leads to `ST_DONE`.
- `ST_DONE`: asserts `done` and always returns to `ST_IDLE`.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done` and `rd_req` are 0, and `ea` and `extra_cyc` read 0.
- R2: Zero page modes (codes 0, 1, 2) give `ea` = {0x00, (op_lo + index) mod 256}. The index is 0, X or Y respectively.
- R3: Absolute modes (codes 3, 4, 5) give `ea` = ({op_hi, op_lo} + index) mod 65536, with no wrap inside the page. The index is 0, X or Y respectively.
- R4: A pointer at address p is read low byte first at p and then high byte at {p[15:8], (p[7:0]+1) mod 256}. For code 6, p = {op_hi, op_lo}, and `ea` is the 16-bit little-endian value read.
- R5: For code 7, p = {0x00, (op_lo + X) mod 256}, and `ea` is the pointer value read.
- R6: For code 8, p = {0x00, op_lo}, and `ea` = (pointer value + Y) mod 65536.
- R7: Code 9 gives `ea` = (pc + sign-extended op_lo) mod 65536, where op_lo values above 0x7F are negative. Code 10 and codes 11 to 15 give `ea` = pc.
- R8: `extra_cyc` is as follows: code 0 gives 1; codes 1, 2 and 3 give 2; codes 4 and 5 give 2, or 3 with `rmw`; codes 6 and 7 give 4; code 8 gives 3, or 4 with `rmw`; all other codes give 0.
- R9: `done` is high for exactly one cycle. For direct modes it comes in the cycle after the `start` edge. For pointer modes it comes in the cycle after the second `rd_ack`.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_ack` is seen. `rd_req` is low in the `done` cycle.
- R11: `start` is ignored while an operation is in progress or `done` is high. The result and the handshake are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (sampled in ST_IDLE) |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| pc | input | 16 | Address of the next instruction |
| rmw | input | 1 | Read-modify-write or store access |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte address |
| rd_ack | input | 1 | Read data valid / request accepted |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| extra_cyc | output | 3 | Extra cycle count for the mode |

## Verification
A wrong state transition shows up at once as a mismatch in `done` latency or as a missing or extra `rd_req` cycle. The bench counts cycles from `start`, so one cycle of slip is caught in the same operation. A wrong pointer address, such as a carry into the page byte, corrupts `ea` in the `done` cycle of that operation. The bench memory returns a different byte for every page, so this cannot pass unnoticed. A stale latch of the mode or the index, or a `start` that is accepted while busy, changes `ea` or `extra_cyc` in the next `done` pulse. It can also leave `done` or `rd_req` high in the cycle after `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [3:0] {
        AM_PAGE0      = 4'd0,
        AM_PAGE0_X    = 4'd1,
        AM_PAGE0_Y    = 4'd2,
        AM_FULL       = 4'd3,
        AM_FULL_X     = 4'd4,
        AM_FULL_Y     = 4'd5,
        AM_PTR        = 4'd6,
        AM_PTR_PRE    = 4'd7,
        AM_PTR_POST   = 4'd8,
        AM_BRANCH     = 4'd9,
        AM_IMM        = 4'd10
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } st_e;
endpackage

// File: rtl/ea_direct.sv
module ea_direct
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]          mode,
    input  logic [DATA_W-1:0]   op_lo,
    input  logic [DATA_W-1:0]   op_hi,
    input  logic [DATA_W-1:0]   x_idx,
    input  logic [DATA_W-1:0]   y_idx,
    input  logic [2*DATA_W-1:0] pc,
    output logic [2*DATA_W-1:0] direct_ea,
    output logic [2*DATA_W-1:0] ptr_addr,
    output logic                needs_ptr
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] page0_x, page0_y;
    logic [ADDR_W-1:0] full;

    always_comb begin
        page0_x   = op_lo + x_idx;
        page0_y   = op_lo + y_idx;
        full      = {op_hi, op_lo};
        direct_ea = pc;
        ptr_addr  = '0;
        needs_ptr = 1'b0;
        case (am_e'(mode))
            AM_PAGE0:    direct_ea = {{DATA_W{1'b0}}, op_lo};
            AM_PAGE0_X:  direct_ea = {{DATA_W{1'b0}}, page0_x};
            AM_PAGE0_Y:  direct_ea = {{DATA_W{1'b0}}, page0_y};
            AM_FULL:     direct_ea = full;
            AM_FULL_X:   direct_ea = full + {{DATA_W{1'b0}}, x_idx};
            AM_FULL_Y:   direct_ea = full + {{DATA_W{1'b0}}, y_idx};
            AM_PTR: begin
                ptr_addr  = full;
                needs_ptr = 1'b1;
            end
            AM_PTR_PRE: begin
                ptr_addr  = {{DATA_W{1'b0}}, page0_x};
                needs_ptr = 1'b1;
            end
            AM_PTR_POST: begin
                ptr_addr  = {{DATA_W{1'b0}}, op_lo};
                needs_ptr = 1'b1;
            end
            AM_BRANCH:   direct_ea = pc + {{DATA_W{op_lo[DATA_W-1]}}, op_lo};
            default:     direct_ea = pc;
        endcase
    end
endmodule

// File: rtl/ea_cost.sv
module ea_cost
    import ea_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic [3:0]       mode,
    input  logic             rmw,
    output logic [CYC_W-1:0] cyc
);
    always_comb begin
        case (am_e'(mode))
            AM_PAGE0:               cyc = CYC_W'(1);
            AM_PAGE0_X, AM_PAGE0_Y: cyc = CYC_W'(2);
            AM_FULL:                cyc = CYC_W'(2);
            AM_FULL_X, AM_FULL_Y:   cyc = rmw ? CYC_W'(3) : CYC_W'(2);
            AM_PTR, AM_PTR_PRE:     cyc = CYC_W'(4);
            AM_PTR_POST:            cyc = rmw ? CYC_W'(4) : CYC_W'(3);
            default:                cyc = '0;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CYC_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          mode,
    input  logic [DATA_W-1:0]   op_lo,
    input  logic [DATA_W-1:0]   op_hi,
    input  logic [DATA_W-1:0]   x_idx,
    input  logic [DATA_W-1:0]   y_idx,
    input  logic [2*DATA_W-1:0] pc,
    input  logic                rmw,
    output logic                rd_req,
    output logic [2*DATA_W-1:0] rd_addr,
    input  logic                rd_ack,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                done,
    output logic [2*DATA_W-1:0] ea,
    output logic [CYC_W-1:0]    extra_cyc
);
    localparam int ADDR_W = 2 * DATA_W;

    st_e               state, state_nx;
    logic [ADDR_W-1:0] direct_ea, ptr_addr, ptr_q, ptr_hi_addr, ea_q;
    logic              needs_ptr, post_q;
    logic [DATA_W-1:0] y_q, lo_q;
    logic [CYC_W-1:0]  cyc_c, cyc_q;

    ea_direct #(.DATA_W(DATA_W)) i_direct (
        .mode(mode), .op_lo(op_lo), .op_hi(op_hi), .x_idx(x_idx),
        .y_idx(y_idx), .pc(pc), .direct_ea(direct_ea),
        .ptr_addr(ptr_addr), .needs_ptr(needs_ptr)
    );

    ea_cost #(.CYC_W(CYC_W)) i_cost (.mode(mode), .rmw(rmw), .cyc(cyc_c));

    // High pointer byte stays on the same page: no carry out of the low byte.
    assign ptr_hi_addr = {ptr_q[ADDR_W-1:DATA_W], ptr_q[DATA_W-1:0] + 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = needs_ptr ? ST_LO : ST_DONE;
            ST_LO:   if (rd_ack) state_nx = ST_HI;
            ST_HI:   if (rd_ack) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req  = 1'b0;
        rd_addr = '0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LO: begin
                rd_req  = 1'b1;
                rd_addr = ptr_q;
            end
            ST_HI: begin
                rd_req  = 1'b1;
                rd_addr = ptr_hi_addr;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            ea_q   <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            cyc_q  <= '0;
            post_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                ptr_q  <= ptr_addr;
                y_q    <= y_idx;
                cyc_q  <= cyc_c;
                post_q <= (am_e'(mode) == AM_PTR_POST);
                if (!needs_ptr) ea_q <= direct_ea;
            end
            if (state == ST_LO && rd_ack) lo_q <= rd_data;
            if (state == ST_HI && rd_ack)
                ea_q <= {rd_data, lo_q} + (post_q ? {{DATA_W{1'b0}}, y_q} : '0);
        end
    end

    assign ea        = ea_q;
    assign extra_cyc = cyc_q;

    // R9: the result strobe lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a pending request holds its address until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R10: no read is pending while the result is presented
    p_no_req_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R4: the second pointer read stays on the page of the first
    p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO && rd_ack) |=>
            (rd_req &&
             rd_addr[ADDR_W-1:DATA_W] == $past(rd_addr[ADDR_W-1:DATA_W]) &&
             rd_addr[DATA_W-1:0] == DATA_W'($past(rd_addr[DATA_W-1:0]) + 1'b1)));

    // R11: start in the done cycle does not begin a new operation
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!rd_req && !done));
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, x_idx = '0, y_idx = '0;
    logic [15:0] pc = '0;
    logic        rmw = 1'b0;
    logic        rd_req, rd_ack = 1'b0, done;
    logic [15:0] rd_addr, ea;
    logic [7:0]  rd_data;
    logic [2:0]  extra_cyc;

    int total = 0, bad = 0, ack_delay = 0, wcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] rd16(input logic [15:0] p);
        return {memf({p[15:8], 8'(p[7:0] + 8'd1)}), memf(p)};
    endfunction

    assign rd_data = memf(rd_addr);

    always @(negedge clk) begin
        if (rd_req) begin
            if (wcnt >= ack_delay) begin rd_ack = 1'b1; wcnt = 0; end
            else begin rd_ack = 1'b0; wcnt = wcnt + 1; end
        end else begin
            rd_ack = 1'b0;
            wcnt = 0;
        end
    end

    ea_gen i_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo),
        .op_hi(op_hi), .x_idx(x_idx), .y_idx(y_idx), .pc(pc), .rmw(rmw),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .ea(ea), .extra_cyc(extra_cyc)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] xv, input logic [7:0] yv, input logic [15:0] pcv,
                       input logic rw, input int dly);
        logic [15:0] exp_ea;
        logic [2:0]  exp_c;
        logic        is_ptr;
        int          lat, exp_lat;
        string       tag;
        is_ptr = (m == 4'd6 || m == 4'd7 || m == 4'd8);
        case (m)
            4'd0:    begin exp_ea = {8'h00, lo};              exp_c = 3'd1; tag = "R2"; end
            4'd1:    begin exp_ea = {8'h00, 8'(lo + xv)};     exp_c = 3'd2; tag = "R2"; end
            4'd2:    begin exp_ea = {8'h00, 8'(lo + yv)};     exp_c = 3'd2; tag = "R2"; end
            4'd3:    begin exp_ea = {hi, lo};                 exp_c = 3'd2; tag = "R3"; end
            4'd4:    begin exp_ea = {hi, lo} + 16'(xv);       exp_c = rw ? 3'd3 : 3'd2; tag = "R3"; end
            4'd5:    begin exp_ea = {hi, lo} + 16'(yv);       exp_c = rw ? 3'd3 : 3'd2; tag = "R3"; end
            4'd6:    begin exp_ea = rd16({hi, lo});           exp_c = 3'd4; tag = "R4"; end
            4'd7:    begin exp_ea = rd16({8'h00, 8'(lo + xv)}); exp_c = 3'd4; tag = "R5"; end
            4'd8:    begin exp_ea = rd16({8'h00, lo}) + 16'(yv); exp_c = rw ? 3'd4 : 3'd3; tag = "R6"; end
            4'd9:    begin exp_ea = pcv + {{8{lo[7]}}, lo};   exp_c = 3'd0; tag = "R7"; end
            default: begin exp_ea = pcv;                      exp_c = 3'd0; tag = "R7"; end
        endcase
        exp_lat = is_ptr ? 2 * (dly + 1) + 1 : 1;
        ack_delay = dly;
        @(negedge clk);
        mode = m; op_lo = lo; op_hi = hi; x_idx = xv; y_idx = yv; pc = pcv; rmw = rw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (is_ptr && !done) begin
            // R11: a start while busy must be ignored
            start = 1'b1; mode = 4'd10; pc = ~pcv; op_lo = ~lo; x_idx = ~xv; y_idx = ~yv; rmw = ~rw;
        end
        while (!done && lat < 64) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(lat == exp_lat, "R9 latency", 32'(lat), 32'(exp_lat));
        chk(ea == exp_ea, tag, 32'(ea), 32'(exp_ea));
        chk(extra_cyc == exp_c, "R8", 32'(extra_cyc), 32'(exp_c));
        chk(!rd_req, "R10 req in done", 32'(rd_req), 32'd0);
        // R11: a start in the done cycle must be ignored
        start = 1'b1; mode = 4'd6; op_lo = ~lo; op_hi = ~hi;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !rd_req, "R11 done pulse/start ignored", {30'd0, done, rd_req}, 32'd0);
        chk(ea == exp_ea, "R11 result held", 32'(ea), 32'(exp_ea));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] xs [5];
        xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'h7F; xs[3] = 8'h80; xs[4] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(!done && !rd_req && ea == 16'h0 && extra_cyc == 3'd0, "R1",
            {done, rd_req, extra_cyc, ea}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_req, "R1 idle", {30'd0, done, rd_req}, 32'd0);
        for (int m = 0; m <= 11; m++) begin
            for (int l = 0; l < 18; l++) begin
                for (int xi = 0; xi < 5; xi++) begin
                    for (int r = 0; r < 2; r++) begin
                        logic [7:0] lo, hi;
                        lo = (l == 17) ? 8'hFF : 8'(l * 15);
                        hi = ~lo;
                        run(4'(m), lo, hi, xs[xi], xs[xi] ^ 8'h3C,
                            {hi ^ 8'h5C, lo ^ 8'hC3}, r[0], (m >= 6 && m <= 8) ? (r * 2) : 0);
                    end
                end
            end
        end
        // R3: absolute indexed wraps at the top of the address space
        run(4'd4, 8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0, 1'b0, 0);
        run(4'd5, 8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0, 1'b1, 0);
        // R4: pointer at the last byte of a page with a slow responder
        run(4'd6, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0, 1'b0, 3);
        // R7: relative branch crossing pages both ways, unused code 15
        run(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0010, 1'b0, 0);
        run(4'd9, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 1'b0, 0);
        run(4'd15, 8'h33, 8'h44, 8'h00, 8'h00, 16'hBEEF, 1'b1, 0);
        summary();
        $finish;
    end
endmodule